// File: doc/BRIEF.md
# External Clock Bypass Controller

This block decides when the root clocks move from their internal oscillators to an external source, and keeps the rest of the clock tree consistent with that choice. It has two triggers. The life cycle controller can raise a request line at any time. Software can also ask for the switch through a 4-bit select field. The select field only counts when it holds one specific pattern and the debug-allowed input is true. A sticky write-enable lock can freeze the select field.

The combined request goes to an analog clock switch over a four-phase req/ack pair. Once the switch reports completion, the block does two things. It acknowledges the life cycle requester, if that requester is still asking. It also tells a set of hardwired strobe dividers to halve their ratio. Each divider applies the new ratio only when its current period wraps.

The controller is a four-state machine:
- `ST_IDLE`: no request is out.
- `ST_REQ`: the request is raised and the block waits for the acknowledge.
- `ST_ON`: the switch is complete and the dividers are stepped down.
- `ST_REL`: the request has been dropped and the block waits for the acknowledge to fall.

The transitions are:
- `ST_IDLE`→`ST_REQ` when a qualified cause appears (*raise*).
- `ST_REQ`→`ST_ON` on acknowledge (*grant*).
- `ST_ON`→`ST_REL` when no cause remains (*withdraw*).
- `ST_REL`→`ST_IDLE` when the acknowledge falls and no cause remains (*settle*).
- `ST_REL`→`ST_REQ` when the acknowledge falls and a cause is present again (*re-raise*).

Top module: `extclk_switch_ctrl`

## Requirements
- R1: After reset, `sel_q_o` reads 0x5, `lock_q_o` reads 1, and `switch_req_o`, `lc_ack_o` and `step_down_o` are 0.
- R2: A write to the select field (`sel_wr_i`) updates `sel_q_o` on the next clock only while `lock_q_o` is 1. While `lock_q_o` is 0, the write leaves `sel_q_o` unchanged.
- R3: Writing the lock with `lock_wdata_i`=1 clears `lock_q_o` to 0. Writing it with 0 has no effect. Once the lock is 0, it stays 0 until reset.
- R4: A software cause exists only when `sel_q_o` equals 0xA and `dbg_en_i` is 1. Any other select value, or `dbg_en_i`=0, produces no request.
- R5: From `ST_IDLE`, a high `lc_req_i` raises `switch_req_o` one clock later, whatever the select field and `dbg_en_i` hold.
- R6: Once raised, `switch_req_o` stays high until `switch_ack_i` is seen high, even if every cause is withdrawn first.
- R7: `lc_ack_o` is 1 only in `ST_ON` while `lc_req_i` is 1, and never before `switch_ack_i` has been seen.
- R8: In `ST_ON`, `step_down_o` is 1 and each divider halves its ratio. `div_tick_o[0]` goes from one strobe every 4 clocks to one every 2 clocks. `div_tick_o[1]` goes from one strobe every 2 clocks to a strobe on every clock.
- R9: A divider changes ratio only on the clock where its current period wraps, so every strobe spacing equals either the old period or the new one.
- R10: When no cause remains in `ST_ON`, `switch_req_o` drops one clock later. The block waits for `switch_ack_i` to fall before another request can be raised. The dividers then return to their base ratios of 4 and 2, and no software input can change those ratios.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_wr_i | input | 1 | Write strobe for the select field |
| sel_wdata_i | input | 4 | Select field write data |
| lock_wr_i | input | 1 | Write strobe for the lock |
| lock_wdata_i | input | 1 | Lock write data; 1 clears the lock |
| sel_q_o | output | 4 | Current select field value |
| lock_q_o | output | 1 | Current lock value; 1 means the select field is writable |
| dbg_en_i | input | 1 | Debug functions allowed; qualifies the software cause |
| lc_req_i | input | 1 | Life cycle request for the external clock |
| lc_ack_o | output | 1 | Acknowledge to the life cycle requester |
| switch_req_o | output | 1 | Request to the analog clock switch |
| switch_ack_i | input | 1 | Completion from the analog clock switch |
| step_down_o | output | 1 | Divider halving command |
| div_tick_o | output | NUM_DIV | Divider strobes; bit i nominally every 2^(NUM_DIV-i) clocks |

## Verification
Register results appear one clock after the write strobe is sampled. `switch_req_o` changes one clock after its cause reaches the state register. For a software cause that is two clocks after the select write, because the write lands first. `lc_ack_o` and `step_down_o` follow one clock after `switch_ack_i` rises. The bench drives every input on the falling edge and samples outputs on the next falling edge, after the counted number of rising edges. Divider ratios are measured by counting strobes over windows that are whole multiples of both periods, started only after enough clocks for any pending wrap.

// File: rtl/extclk_pkg.sv
package extclk_pkg;

    localparam int unsigned SEL_W = 4;
    localparam logic [SEL_W-1:0] SEL_RST = 4'h5;
    localparam logic [SEL_W-1:0] SEL_EXT = 4'hA;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_ON   = 2'd2,
        ST_REL  = 2'd3
    } sw_state_e;

endpackage

// File: rtl/extclk_sel_reg.sv
module extclk_sel_reg
    import extclk_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sel_wr_i,
    input  logic [SEL_W-1:0] sel_wdata_i,
    input  logic             lock_wr_i,
    input  logic             lock_wdata_i,
    input  logic             dbg_en_i,
    output logic [SEL_W-1:0] sel_q_o,
    output logic             lock_q_o,
    output logic             sw_cause_o
);

    logic [SEL_W-1:0] sel_q;
    logic             lock_q;

    // Lock: write one to clear, sticky until reset
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lock_q <= 1'b1;
        end else if (lock_wr_i && lock_wdata_i) begin
            lock_q <= 1'b0;
        end
    end

    // Select field is writable only while unlocked
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sel_q <= SEL_RST;
        end else if (sel_wr_i && lock_q) begin
            sel_q <= sel_wdata_i;
        end
    end

    assign sel_q_o    = sel_q;
    assign lock_q_o   = lock_q;
    assign sw_cause_o = (sel_q == SEL_EXT) && dbg_en_i;

endmodule

// File: rtl/extclk_switch_fsm.sv
module extclk_switch_fsm
    import extclk_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sw_cause_i,
    input  logic lc_req_i,
    input  logic switch_ack_i,
    output logic switch_req_o,
    output logic lc_ack_o,
    output logic step_down_o
);

    sw_state_e state_q, state_d;
    logic      want;

    assign want = sw_cause_i || lc_req_i;

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (want)          state_d = ST_REQ;   // raise
            ST_REQ:  if (switch_ack_i)  state_d = ST_ON;    // grant
            ST_ON:   if (!want)         state_d = ST_REL;   // withdraw
            ST_REL:  if (!switch_ack_i) state_d = want ? ST_REQ : ST_IDLE; // re-raise / settle
            default:                    state_d = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        switch_req_o = 1'b0;
        lc_ack_o     = 1'b0;
        step_down_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ:  switch_req_o = 1'b1;
            ST_ON: begin
                switch_req_o = 1'b1;
                step_down_o  = 1'b1;
                lc_ack_o     = lc_req_i;
            end
            ST_REL:  ;
            default: ;
        endcase
    end

endmodule

// File: rtl/extclk_div_strobe.sv
module extclk_div_strobe #(
    parameter int unsigned BASE_LOG2 = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic step_i,
    output logic tick_o
);

    localparam int unsigned CW = (BASE_LOG2 < 1) ? 1 : BASE_LOG2;
    localparam logic [CW-1:0] LAST_BASE = CW'((1 << BASE_LOG2) - 1);
    localparam logic [CW-1:0] LAST_HALF = CW'((1 << (BASE_LOG2 - 1)) - 1);

    logic [CW-1:0] cnt_q;
    logic          half_q;
    logic [CW-1:0] last;
    logic          wrap;

    assign last = half_q ? LAST_HALF : LAST_BASE;
    assign wrap = (cnt_q == last);

    // Ratio changes only at the period wrap
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            half_q <= 1'b0;
        end else if (wrap) begin
            cnt_q  <= '0;
            half_q <= step_i;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign tick_o = wrap;

endmodule

// File: rtl/extclk_switch_ctrl.sv
module extclk_switch_ctrl
    import extclk_pkg::*;
#(
    parameter int unsigned NUM_DIV = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               sel_wr_i,
    input  logic [SEL_W-1:0]   sel_wdata_i,
    input  logic               lock_wr_i,
    input  logic               lock_wdata_i,
    output logic [SEL_W-1:0]   sel_q_o,
    output logic               lock_q_o,
    input  logic               dbg_en_i,
    input  logic               lc_req_i,
    output logic               lc_ack_o,
    output logic               switch_req_o,
    input  logic               switch_ack_i,
    output logic               step_down_o,
    output logic [NUM_DIV-1:0] div_tick_o
);

    logic sw_cause;
    logic step;

    extclk_sel_reg u_sel (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sel_wr_i     (sel_wr_i),
        .sel_wdata_i  (sel_wdata_i),
        .lock_wr_i    (lock_wr_i),
        .lock_wdata_i (lock_wdata_i),
        .dbg_en_i     (dbg_en_i),
        .sel_q_o      (sel_q_o),
        .lock_q_o     (lock_q_o),
        .sw_cause_o   (sw_cause)
    );

    extclk_switch_fsm u_fsm (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .sw_cause_i   (sw_cause),
        .lc_req_i     (lc_req_i),
        .switch_ack_i (switch_ack_i),
        .switch_req_o (switch_req_o),
        .lc_ack_o     (lc_ack_o),
        .step_down_o  (step)
    );

    assign step_down_o = step;

    // Divider i has a hardwired base ratio of 2^(NUM_DIV-i)
    for (genvar i = 0; i < NUM_DIV; i++) begin : g_div
        extclk_div_strobe #(
            .BASE_LOG2 (NUM_DIV - i)
        ) u_div (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .step_i (step),
            .tick_o (div_tick_o[i])
        );
    end

endmodule

// File: rtl/extclk_switch_ctrl_chk.sv
module extclk_switch_ctrl_chk #(
    parameter int unsigned NUM_DIV = 2
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               sel_wr_i,
    input logic [3:0]         sel_q_o,
    input logic               lock_q_o,
    input logic               lc_req_i,
    input logic               lc_ack_o,
    input logic               switch_req_o,
    input logic               switch_ack_i,
    input logic               step_down_o,
    input logic [NUM_DIV-1:0] div_tick_o
);

    AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lock_q_o |=> !lock_q_o); // R3

    AST_SEL_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lock_q_o || !sel_wr_i) |=> $stable(sel_q_o)); // R2

    AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (switch_req_o && !switch_ack_i) |=> switch_req_o); // R6

    AST_LC_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lc_req_i && !switch_req_o && !switch_ack_i) |=> switch_req_o); // R5

    AST_LC_ACK_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lc_ack_o |-> (lc_req_i && switch_req_o && switch_ack_i)); // R7

    AST_STEP_ONLY_GRANTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_down_o |-> switch_req_o); // R8

    AST_SLOW_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (div_tick_o[0] && !step_down_o && !$past(step_down_o)) |=> !div_tick_o[0]); // R9

endmodule

bind extclk_switch_ctrl extclk_switch_ctrl_chk #(.NUM_DIV(NUM_DIV)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_wr_i     (sel_wr_i),
    .sel_q_o      (sel_q_o),
    .lock_q_o     (lock_q_o),
    .lc_req_i     (lc_req_i),
    .lc_ack_o     (lc_ack_o),
    .switch_req_o (switch_req_o),
    .switch_ack_i (switch_ack_i),
    .step_down_o  (step_down_o),
    .div_tick_o   (div_tick_o)
);

// File: tb/extclk_switch_ctrl_bench.sv
module extclk_switch_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr = 1'b0;
    logic [3:0] sel_wdata = 4'h0;
    logic       lock_wr = 1'b0;
    logic       lock_wdata = 1'b0;
    logic [3:0] sel_q;
    logic       lock_q;
    logic       dbg_en = 1'b0;
    logic       lc_req = 1'b0;
    logic       lc_ack;
    logic       sw_req;
    logic       sw_ack = 1'b0;
    logic       step;
    logic [1:0] tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    extclk_switch_ctrl #(.NUM_DIV(2)) u_extclk_switch_ctrl (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sel_wr_i     (sel_wr),
        .sel_wdata_i  (sel_wdata),
        .lock_wr_i    (lock_wr),
        .lock_wdata_i (lock_wdata),
        .sel_q_o      (sel_q),
        .lock_q_o     (lock_q),
        .dbg_en_i     (dbg_en),
        .lc_req_i     (lc_req),
        .lc_ack_o     (lc_ack),
        .switch_req_o (sw_req),
        .switch_ack_i (sw_ack),
        .step_down_o  (step),
        .div_tick_o   (tick)
    );

    typedef struct packed {
        logic [3:0] sel;
        logic       dbg;
        logic       exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{4'hA, 1'b1, 1'b1},
        '{4'hA, 1'b0, 1'b0},
        '{4'h5, 1'b1, 1'b0},
        '{4'hB, 1'b1, 1'b0},
        '{4'h2, 1'b1, 1'b0},
        '{4'hF, 1'b0, 1'b0},
        '{4'h0, 1'b1, 1'b0},
        '{4'hE, 1'b1, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_sel(input logic [3:0] v);
        @(negedge clk);
        sel_wr = 1'b1; sel_wdata = v;
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    // Acts as the analog switch: ack follows req, for n clocks
    task automatic respond(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            sw_ack = sw_req;
        end
    endtask

    task automatic count_ticks(input int n, output int c0, output int c1);
        c0 = 0; c1 = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c0 += int'(tick[0]);
            c1 += int'(tick[1]);
        end
    endtask

    initial begin
        int c0, c1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(sel_q == 4'h5, "R1 sel", sel_q, 5);
        check(lock_q == 1'b1, "R1 lock", lock_q, 1);
        check(!sw_req && !lc_ack && !step, "R1 outputs", {sw_req, lc_ack, step}, 0);

        // R10 base ratios
        count_ticks(16, c0, c1);
        check(c0 == 4, "R10 base div4", c0, 4);
        check(c1 == 8, "R10 base div2", c1, 8);

        // R4 vector table: select value and debug qualifier
        foreach (VECS[k]) begin
            dbg_en = VECS[k].dbg;
            write_sel(VECS[k].sel);   // sel lands at the first edge
            @(negedge clk);           // FSM sees cause at the second edge
            check(sel_q == VECS[k].sel, "R2 sel write", sel_q, VECS[k].sel);
            check(sw_req == VECS[k].exp, "R4 sw cause", sw_req, VECS[k].exp);
            @(negedge clk);
            sel_wr = 1'b1; sel_wdata = 4'h5;
            @(negedge clk);
            sel_wr = 1'b0;
            respond(6);
            check(!sw_req && !sw_ack, "R10 settle", sw_req, 0);
        end
        dbg_en = 1'b0;

        // R5/R6/R7 life cycle flow with delayed ack
        @(negedge clk);
        lc_req = 1'b1;
        @(negedge clk);
        check(sw_req == 1'b1, "R5 lc forward", sw_req, 1);
        check(lc_ack == 1'b0, "R7 no early ack", lc_ack, 0);
        repeat (3) @(negedge clk);
        check(sw_req == 1'b1, "R6 held", sw_req, 1);
        check(lc_ack == 1'b0, "R7 ack waits", lc_ack, 0);
        sw_ack = 1'b1;
        @(negedge clk);
        check(lc_ack == 1'b1, "R7 lc ack", lc_ack, 1);
        check(step == 1'b1, "R8 step", step, 1);

        // R8/R9 halved ratios after the boundary
        repeat (8) @(negedge clk);
        count_ticks(8, c0, c1);
        check(c0 == 4, "R8 div4 to div2", c0, 4);
        check(c1 == 8, "R8 div2 to div1", c1, 8);

        // R10 withdraw and release
        lc_req = 1'b0;
        @(negedge clk);
        check(lc_ack == 1'b0, "R7 ack follows req", lc_ack, 0);
        @(negedge clk);
        check(sw_req == 1'b0, "R10 req drops", sw_req, 0);
        sw_ack = 1'b0;
        repeat (2) @(negedge clk);
        check(!sw_req && !step, "R10 idle", sw_req, 0);
        repeat (8) @(negedge clk);
        count_ticks(16, c0, c1);
        check(c0 == 4 && c1 == 8, "R10 ratios restored", c0 * 10 + c1, 48);

        // R6 cause withdrawn before ack
        lc_req = 1'b1;
        @(negedge clk);
        lc_req = 1'b0;
        repeat (2) @(negedge clk);
        check(sw_req == 1'b1, "R6 held after withdraw", sw_req, 1);
        respond(6);
        check(!sw_req && !sw_ack, "R10 release after late ack", sw_req, 0);

        // R3/R2 lock behaviour
        @(negedge clk);
        lock_wr = 1'b1; lock_wdata = 1'b0;
        @(negedge clk);
        lock_wr = 1'b0;
        check(lock_q == 1'b1, "R3 write zero ignored", lock_q, 1);
        @(negedge clk);
        lock_wr = 1'b1; lock_wdata = 1'b1;
        @(negedge clk);
        lock_wr = 1'b0;
        check(lock_q == 1'b0, "R3 clear", lock_q, 0);
        dbg_en = 1'b1;
        write_sel(4'hA);
        @(negedge clk);
        check(sel_q == 4'h5, "R2 locked write ignored", sel_q, 5);
        check(sw_req == 1'b0, "R2 no request when locked", sw_req, 0);
        @(negedge clk);
        lock_wr = 1'b1; lock_wdata = 1'b1;
        @(negedge clk);
        lock_wr = 1'b0; lock_wdata = 1'b0;
        repeat (3) @(negedge clk);
        check(lock_q == 1'b0, "R3 sticky", lock_q, 0);

        // R1 reset restores lock and select
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(lock_q == 1'b1 && sel_q == 4'h5, "R1 after reset", {lock_q, sel_q}, 21);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule